// File: doc/BRIEF.md
# Programmable Feed-Forward Bit Scrambler

This block scrambles a serial bit stream with a feed-forward network over GF(2). On each clock where the valid strobe is high it takes one bit. It shifts that bit into a short delay line and produces one output bit. The output is the XOR of the current bit and the held past bits, with each term enabled by one coefficient bit. The coefficient set is a polynomial in the unit-delay operator. It is held in a register that can be rewritten at run time, so the scrambling code can change between or during messages.

The delay line clears to zero on reset. A message that starts after reset is therefore handled as if zeros came before it. Two instances chained output-to-input act as one instance whose polynomial is the GF(2) product of their two polynomials. The chained result arrives one clock later because of the extra output register.

Top module: `fwd_scrambler`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bit_out` and `out_valid` are 0. The delay line is cleared, so the first bit after reset sees zero history.
- R2: On a clock where `bit_valid` is high, `bit_out` becomes c0·x(n) ⊕ c1·x(n-1) ⊕ c2·x(n-2) ⊕ c3·x(n-3). Here x(n) is `bit_in`, x(n-k) is the k-th earlier accepted bit, and ci is `coef_in` bit i as held in the coefficient register (bit 0 multiplies the current bit).
- R3: The delay line shifts once per accepted bit, so stage m holds the bit accepted m accepted bits earlier. An isolated 1 followed by zeros returns c0, c1, c2, c3 in that order.
- R4: On a clock where `bit_valid` is low, the delay line does not shift and `bit_out` keeps its value, whatever `bit_in` does.
- R5: A value on `coef_in` with `coef_load` high is captured at that clock edge. A bit accepted at the same edge still uses the previous coefficients; bits accepted at later edges use the new ones.
- R6: Loading coefficients leaves the delay line unchanged.
- R7: `out_valid` is `bit_valid` delayed by exactly one clock.
- R8: Reset sets the coefficients to 0001 (c0 only), so the block passes bits straight through until it is loaded.
- R9: Two instances in series equal one instance loaded with the GF(2) product of their polynomials (for products of degree at most 3), with one extra clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Capture `coef_in` into the coefficient register |
| coef_in | input | ORDER+1 | New coefficients; bit i multiplies x(n-i) |
| bit_valid | input | 1 | `bit_in` carries a bit this clock |
| bit_in | input | 1 | Serial input bit |
| bit_out | output | 1 | Scrambled output bit, registered |
| out_valid | output | 1 | `bit_out` was produced by the previous clock |

## Verification
The bench drives an isolated 1 and checks that the output reproduces the coefficients in order. A design with reversed taps or a missing delay stage would emit them permuted or shifted.

Idle gaps are placed mid-message while `bit_in` toggles. A design that shifts on every clock would corrupt the later bits, and one with an unheld output would flicker during the gaps.

Coefficient loads land both on a valid bit and between bits. A load that takes effect one clock early, or that clears the history, would give wrong bits right after the load.

A reset in mid-stream and a chained pair compared against the product polynomial catch leftover history and a wrong tap order.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int unsigned SCR_ORDER_DEFAULT = 3;
    localparam int unsigned SCR_MAX_TAPS      = 32;

    // one registered output beat
    typedef struct packed {
        logic valid;
        logic data;
    } scr_beat_t;

    // modulo-2 sum of all set bits
    function automatic logic gf2_sum(input logic [SCR_MAX_TAPS-1:0] v);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < SCR_MAX_TAPS; i++) acc = acc ^ v[i];
        return acc;
    endfunction

endpackage

// File: rtl/scr_coef_reg.sv
module scr_coef_reg #(
    parameter int unsigned TAPS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TAPS-1:0] coef_in,
    output logic [TAPS-1:0] coef_q
);
    localparam logic [TAPS-1:0] COEF_RESET = TAPS'(1);

    always_ff @(posedge clk) begin
        if (rst)       coef_q <= COEF_RESET;
        else if (load) coef_q <= coef_in;
    end
endmodule

// File: rtl/scr_history.sv
module scr_history #(
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [ORDER-1:0] hist_q
);
    // hist_q[k] holds the bit accepted k+1 accepted bits ago
    generate
        if (ORDER == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[ORDER-2:0], din};
            end
        end
    endgenerate
endmodule

// File: rtl/scr_tap_combiner.sv
module scr_tap_combiner #(
    parameter int unsigned TAPS = 4
) (
    input  logic [TAPS-1:0] coef,
    input  logic [TAPS-1:0] window,
    output logic            sum
);
    logic [TAPS-1:0] gated;
    logic [TAPS:0]   chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign gated[i]   = coef[i] & window[i];
            assign chain[i+1] = chain[i] ^ gated[i];
        end
    endgenerate

    assign sum = chain[TAPS];
endmodule

// File: rtl/fwd_scrambler.sv
module fwd_scrambler #(
    parameter int unsigned ORDER = scr_pkg::SCR_ORDER_DEFAULT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           coef_load,
    input  logic [ORDER:0] coef_in,
    input  logic           bit_valid,
    input  logic           bit_in,
    output logic           bit_out,
    output logic           out_valid
);
    import scr_pkg::*;

    localparam int unsigned TAPS = ORDER + 1;

    logic [TAPS-1:0]  coef_q;
    logic [ORDER-1:0] hist_q;
    logic [TAPS-1:0]  window;
    logic             tap_sum;
    scr_beat_t        beat_q;

    scr_coef_reg #(.TAPS(TAPS)) u_coef (
        .clk     (clk),
        .rst     (rst),
        .load    (coef_load),
        .coef_in (coef_in),
        .coef_q  (coef_q)
    );

    scr_history #(.ORDER(ORDER)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_valid),
        .din      (bit_in),
        .hist_q   (hist_q)
    );

    assign window = {hist_q, bit_in};

    scr_tap_combiner #(.TAPS(TAPS)) u_comb (
        .coef   (coef_q),
        .window (window),
        .sum    (tap_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= bit_valid;
            if (bit_valid) beat_q.data <= tap_sum;
        end
    end

    assign bit_out   = beat_q.data;
    assign out_valid = beat_q.valid;
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int unsigned ORDER = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           coef_load,
    input logic [ORDER:0] coef_in,
    input logic           bit_valid,
    input logic           bit_in,
    input logic           bit_out,
    input logic           out_valid,
    input logic [ORDER:0] coef_q,
    input logic [ORDER-1:0] hist_q
);
    localparam int unsigned TAPS = ORDER + 1;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !bit_out && hist_q == '0));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> out_valid);

    a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> !out_valid);

    a_r4_output_held: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(bit_out));

    a_r4_history_held: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(hist_q));

    a_r2_output_sum: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> bit_out == scr_pkg::gf2_sum(
            scr_pkg::SCR_MAX_TAPS'($past(coef_q) & {$past(hist_q), $past(bit_in)})));

    a_r5_coef_capture: assert property (@(posedge clk) disable iff (rst)
        coef_load |=> coef_q == $past(coef_in));

    a_r6_load_keeps_history: assert property (@(posedge clk) disable iff (rst)
        (coef_load && !bit_valid) |=> $stable(hist_q));

    a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> hist_q[0] == $past(bit_in));
endmodule

bind fwd_scrambler scr_checker #(.ORDER(ORDER)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .coef_load (coef_load),
    .coef_in   (coef_in),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .bit_out   (bit_out),
    .out_valid (out_valid),
    .coef_q    (coef_q),
    .hist_q    (hist_q)
);

// File: tb/fwd_scrambler_test.sv
module fwd_scrambler_test;
    localparam int  ORDER    = 3;
    localparam int  TAPS     = ORDER + 1;
    localparam time CLK_HALF = 5;
    localparam time CLK_PER  = 2 * CLK_HALF;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coef_load = 1'b0;
    logic [ORDER:0] coef_in = '0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic bit_out, out_valid;

    logic load_a = 1'b0, load_b = 1'b0, load_p = 1'b0;
    logic [ORDER:0] coef_a = '0, coef_b = '0, coef_p = '0;
    logic a_out, a_vld, b_out, b_vld, p_out, p_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit seen   = 1'b0;
    logic last_out = 1'b0;

    logic [ORDER:0]   m_coef;
    logic [ORDER-1:0] m_hist;
    string            cur_tag = "R2";

    exp_t exp_q[$];
    logic cas_q[$];

    always #CLK_HALF clk = ~clk;

    fwd_scrambler #(.ORDER(ORDER)) uut (
        .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .bit_out(bit_out), .out_valid(out_valid));

    fwd_scrambler #(.ORDER(ORDER)) cas_a (
        .clk(clk), .rst(rst), .coef_load(load_a), .coef_in(coef_a),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .bit_out(a_out), .out_valid(a_vld));

    fwd_scrambler #(.ORDER(ORDER)) cas_b (
        .clk(clk), .rst(rst), .coef_load(load_b), .coef_in(coef_b),
        .bit_valid(a_vld), .bit_in(a_out),
        .bit_out(b_out), .out_valid(b_vld));

    fwd_scrambler #(.ORDER(ORDER)) prod (
        .clk(clk), .rst(rst), .coef_load(load_p), .coef_in(coef_p),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .bit_out(p_out), .out_valid(p_vld));

    function automatic logic [ORDER:0] gf2_mul(input logic [ORDER:0] x, input logic [ORDER:0] y);
        logic [ORDER:0] r;
        r = '0;
        for (int i = 0; i <= ORDER; i++)
            if (x[i]) r = r ^ (y << i);
        return r;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: scoreboard pop and hold checks
    always @(negedge clk) begin
        if (rst) begin
            seen = 1'b0;
        end else if (out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected out_valid", 1'b1, 1'b0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, bit_out, e.b);
                last_out = e.b;
                seen = 1'b1;
            end
        end else if (seen) begin
            check("R4 hold while idle", bit_out, last_out);
        end
        if (!rst && p_vld) cas_q.push_back(p_out);
        if (!rst && b_vld) begin
            if (cas_q.size() == 0) check("R9 cascade early", 1'b1, 1'b0);
            else check("R9 cascade vs product", b_out, cas_q.pop_front());
        end
    end

    // driver: one clock of stimulus, model update, push expectation
    task automatic drive(input logic v, input logic b, input logic ld, input logic [ORDER:0] c);
        @(negedge clk);
        bit_valid = v;
        bit_in    = b;
        coef_load = ld;
        coef_in   = c;
        if (v) begin
            exp_t e;
            e.b   = ^(m_coef & {m_hist, b});
            e.tag = cur_tag;
            exp_q.push_back(e);
            m_hist = {m_hist[ORDER-2:0], b};
        end
        if (ld) m_coef = c;
    endtask

    task automatic send(input logic b);
        drive(1'b1, b, 1'b0, '0);
    endtask

    task automatic idle_toggle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, i[0], 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        bit_valid = 1'b0;
        coef_load = 1'b0;
        load_a = 1'b0; load_b = 1'b0; load_p = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 out_valid in reset", out_valid, 1'b0);
        rst = 1'b0;
        m_coef = TAPS'(1);
        m_hist = '0;
        @(negedge clk);
        #1;
        check("R1 bit_out after reset", bit_out, 1'b0);
        check("R1 out_valid after reset", out_valid, 1'b0);
    endtask

    task automatic load_cascade(input logic [ORDER:0] ca, input logic [ORDER:0] cb);
        @(negedge clk);
        coef_a = ca; coef_b = cb; coef_p = gf2_mul(ca, cb);
        load_a = 1'b1; load_b = 1'b1; load_p = 1'b1;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0; load_p = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        m_coef = TAPS'(1);
        m_hist = '0;
        repeat (3) @(negedge clk);
        do_reset();
        load_cascade(4'b0011, 4'b0101);   // (1+D)(1+D^2) = 1+D+D^2+D^3

        // R8: reset coefficients pass bits straight through
        cur_tag = "R8 reset passthrough";
        send(1'b1); send(1'b0); send(1'b1); send(1'b1);

        // R3: impulse response reproduces c0..c3 in order
        cur_tag = "R3 impulse";
        drive(1'b0, 1'b0, 1'b1, 4'b1101);
        repeat (3) send(1'b0);
        send(1'b1);
        repeat (4) send(1'b0);

        // R2: pseudo-random pattern under several coefficient sets
        lfsr = 16'hACE1;
        cur_tag = "R2 pattern";
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 1'b1, ORDER'(k) * 4'd5 + 4'd3);
            for (int j = 0; j < 12; j++) begin
                send(lfsr[0]);
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        end

        // R4: idle gaps with toggling input keep history and output
        cur_tag = "R4 after gap";
        send(1'b1); send(1'b1);
        idle_toggle(4);
        send(1'b0); send(1'b1);
        idle_toggle(3);
        send(1'b0);

        // R5: load coinciding with a valid bit uses old coefficients
        cur_tag = "R5 load same clock";
        drive(1'b1, 1'b1, 1'b1, 4'b1010);
        cur_tag = "R5 after load";
        send(1'b0); send(1'b1); send(1'b1);

        // R6: load during idle keeps history
        send(1'b1); send(1'b0); send(1'b1);
        drive(1'b0, 1'b0, 1'b1, 4'b1111);
        cur_tag = "R6 history kept";
        send(1'b0); send(1'b0); send(1'b0);
        idle_toggle(2);

        // R1: mid-stream reset clears history
        do_reset();
        load_cascade(4'b0011, 4'b0011);   // (1+D)^2 = 1+D^2
        drive(1'b0, 1'b0, 1'b1, 4'b1110);
        cur_tag = "R1 history cleared";
        send(1'b1); send(1'b0); send(1'b0); send(1'b0);

        // R9: more traffic through the second cascade pair
        cur_tag = "R2 pattern";
        for (int j = 0; j < 20; j++) begin
            send(lfsr[1]);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        idle_toggle(5);
        if (exp_q.size() != 0) check("R7 outputs missing", 1'b1, 1'b0);
        if (cas_q.size() != 0) check("R9 cascade missing", 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule